// File: doc/BRIEF.md
# Virtual-Aware Interrupt Pending Register and Winner Selector

This block keeps one pending bit for each interrupt source of a processor core: seven in all, covering physical IRQ, physical FIQ, external abort, virtual IRQ, virtual FIQ, reset and send-event. Single-source post and clear ports change these bits, and a clear-all input zeroes every bit. A post or clear that names a source that does not exist, or that carries a nonzero sub-index, changes nothing and raises an error pulse.

Every output is combinational. It is formed from the registered pending bits and from live core-state inputs: the I/F/A mask bits, the three routing bits, the three hypervisor virtual-assert bits, the secure-state flag and the hypervisor-mode flag. The take decisions for the physical sources come in from outside. From all of this the block forms four results: a take request, a 3-bit code that names the single winning source under a fixed priority order, a wake signal for wait-for-interrupt that ignores the masks, and a 3-bit status view. Each bit of the status view shows either the physical source or the virtual source, depending on routing and core state.

Top module: `vint_select`

## Requirements
- R1: A post of a valid source number, with sub-index zero, sets that pending bit on the clock edge, and its effect shows on the outputs in the following cycle. Source numbers: 0 IRQ, 1 FIQ, 2 abort, 3 virtual IRQ, 4 virtual FIQ, 5 reset, 6 send-event.
- R2: A valid clear resets its bit. When a post and a clear name the same source in one cycle, the clear wins. `clr_all` zeroes every bit, overriding any post in the same cycle.
- R3: Synchronous active-high `rst` zeroes every pending bit and the error pulse.
- R4: A virtual class (I, F or A) is routed when its routing bit is 1 and both `sec_state` and `hyp_mode` are 0. It is allowed when it is routed and its mask bit is 0. Virtual IRQ is present when its bit or `hv_vi` is set. Virtual FIQ is present when its bit or `hv_vf` is set. Virtual abort is present only when `hv_va` is set.
- R5: `take_req` is 1 when any of these holds: a pending physical IRQ, FIQ or abort whose take input is 1; a present and allowed virtual source; a pending reset; a pending send-event.
- R6: While `take_req` is 1, `take_code` names the first qualifying source in this order: 0 IRQ, 1 virtual IRQ, 2 FIQ, 3 virtual FIQ, 4 abort, 5 virtual abort, 6 reset, 7 send-event.
- R7: `wfi_wake` is 1 when any pending bit other than virtual IRQ or virtual FIQ is set, or when any virtual source is both present and routed. The mask bits have no effect on it.
- R8: `stat_view` bit 0 (I), bit 1 (F) and bit 2 (A) each show the present state of their virtual source when that class is routed. Otherwise each shows the physical IRQ, FIQ or abort pending bit.
- R9: A post or clear whose number is 7 or higher, or whose sub-index is nonzero, changes no bit and makes `err_pulse` 1 for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_en | input | 1 | Post strobe |
| post_num | input | NUM_W | Source number to post |
| post_sub | input | SUB_W | Sub-index of post, must be zero |
| clr_en | input | 1 | Clear strobe |
| clr_num | input | NUM_W | Source number to clear |
| clr_sub | input | SUB_W | Sub-index of clear, must be zero |
| clr_all | input | 1 | Zero all pending bits |
| mask_i | input | 1 | Core IRQ mask |
| mask_f | input | 1 | Core FIQ mask |
| mask_a | input | 1 | Core abort mask |
| rt_imo | input | 1 | Route IRQ class to virtual |
| rt_fmo | input | 1 | Route FIQ class to virtual |
| rt_amo | input | 1 | Route abort class to virtual |
| hv_vi | input | 1 | Hypervisor virtual IRQ assert |
| hv_vf | input | 1 | Hypervisor virtual FIQ assert |
| hv_va | input | 1 | Hypervisor virtual abort assert |
| sec_state | input | 1 | Core is in secure state |
| hyp_mode | input | 1 | Core is in hypervisor mode |
| take_irq_ok | input | 1 | Physical IRQ may be taken |
| take_fiq_ok | input | 1 | Physical FIQ may be taken |
| take_abt_ok | input | 1 | Physical abort may be taken |
| take_req | output | 1 | Interrupt should be taken |
| take_code | output | 3 | Winning source code |
| wfi_wake | output | 1 | Wake from wait-for-interrupt |
| stat_view | output | 3 | Status bits {A,F,I} |
| err_pulse | output | 1 | Bad post or clear seen last cycle |

## Verification
A post, clear, clear-all or reset changes the pending bits on one edge. Its effect on `take_req`, `take_code`, `wfi_wake` and `stat_view` is therefore due in the cycle after that edge, and `err_pulse` follows the bad request by exactly one cycle. A change on a core-state input reaches these same outputs in the same cycle, with no edge in between. The bench keeps a behavioural model of the pending bits that updates at the rising edge and compares every output at the falling edge. Directed checks change only core-state inputs and then sample after a short delay inside the low phase, so each sample lands after all register delays and before the next edge.

// File: rtl/vint_pkg.sv
package vint_pkg;
   localparam int NUM_SRC  = 7;
   localparam int NUM_CLS  = 3;
   localparam int NUM_WIN  = 8;
   localparam int SRC_IRQ  = 0;
   localparam int SRC_FIQ  = 1;
   localparam int SRC_ABT  = 2;
   localparam int SRC_VIRQ = 3;
   localparam int SRC_VFIQ = 4;
   localparam int SRC_RST  = 5;
   localparam int SRC_SEV  = 6;
   localparam logic [NUM_SRC-1:0] VIRT_BITS =
      (NUM_SRC'(1) << SRC_VIRQ) | (NUM_SRC'(1) << SRC_VFIQ);
endpackage

// File: rtl/vint_flags.sv
module vint_flags
   import vint_pkg::*;
#(
   parameter int NUM_W = 4,
   parameter int SUB_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               post_en,
   input  logic [NUM_W-1:0]   post_num,
   input  logic [SUB_W-1:0]   post_sub,
   input  logic               clr_en,
   input  logic [NUM_W-1:0]   clr_num,
   input  logic [SUB_W-1:0]   clr_sub,
   input  logic               clr_all,
   output logic [NUM_SRC-1:0] flags,
   output logic               err_pulse
);
   localparam logic [NUM_W-1:0] LAST = NUM_W'(NUM_SRC - 1);

   logic post_good, clr_good, post_bad, clr_bad;

   assign post_good = (post_num <= LAST) && (post_sub == '0);
   assign clr_good  = (clr_num  <= LAST) && (clr_sub  == '0);
   assign post_bad  = post_en && !post_good;
   assign clr_bad   = clr_en  && !clr_good;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
      logic set_k, kill_k;
      assign set_k  = post_en && post_good && (post_num == NUM_W'(k));
      assign kill_k = clr_en  && clr_good  && (clr_num  == NUM_W'(k));
      always_ff @(posedge clk) begin
         if (rst || clr_all)  flags[k] <= 1'b0;
         else if (kill_k)     flags[k] <= 1'b0;
         else if (set_k)      flags[k] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) err_pulse <= 1'b0;
      else     err_pulse <= post_bad || clr_bad;
   end
endmodule

// File: rtl/vint_gate.sv
module vint_gate
   import vint_pkg::*;
(
   input  logic [NUM_CLS-1:0] mask,
   input  logic [NUM_CLS-1:0] route,
   input  logic [NUM_CLS-1:0] hv_set,
   input  logic [NUM_CLS-1:0] vflag,
   input  logic               sec_state,
   input  logic               hyp_mode,
   output logic [NUM_CLS-1:0] present,
   output logic [NUM_CLS-1:0] routed,
   output logic [NUM_CLS-1:0] allowed
);
   logic guest_ok;
   assign guest_ok = !sec_state && !hyp_mode;

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      assign present[c] = hv_set[c] || vflag[c];
      assign routed[c]  = route[c] && guest_ok;
      assign allowed[c] = routed[c] && !mask[c];
   end
endmodule

// File: rtl/vint_prio.sv
module vint_prio #(
   parameter int N = 8,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] cand,
   output logic         valid,
   output logic [W-1:0] code
);
   always_comb begin
      code = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) code = W'(i);
      end
   end
   assign valid = |cand;
endmodule

// File: rtl/vint_select.sv
module vint_select
   import vint_pkg::*;
#(
   parameter int NUM_W = 4,
   parameter int SUB_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             post_en,
   input  logic [NUM_W-1:0] post_num,
   input  logic [SUB_W-1:0] post_sub,
   input  logic             clr_en,
   input  logic [NUM_W-1:0] clr_num,
   input  logic [SUB_W-1:0] clr_sub,
   input  logic             clr_all,
   input  logic             mask_i,
   input  logic             mask_f,
   input  logic             mask_a,
   input  logic             rt_imo,
   input  logic             rt_fmo,
   input  logic             rt_amo,
   input  logic             hv_vi,
   input  logic             hv_vf,
   input  logic             hv_va,
   input  logic             sec_state,
   input  logic             hyp_mode,
   input  logic             take_irq_ok,
   input  logic             take_fiq_ok,
   input  logic             take_abt_ok,
   output logic             take_req,
   output logic [2:0]       take_code,
   output logic             wfi_wake,
   output logic [2:0]       stat_view,
   output logic             err_pulse
);
   if (NUM_W < 3) begin : g_bad_num
      $error("NUM_W must hold source numbers up to %0d", NUM_SRC - 1);
   end
   if (SUB_W < 1) begin : g_bad_sub
      $error("SUB_W must be at least 1");
   end

   logic [NUM_SRC-1:0] flags;
   logic [NUM_CLS-1:0] present, routed, allowed, phys;
   logic [NUM_WIN-1:0] cand;

   vint_flags #(.NUM_W(NUM_W), .SUB_W(SUB_W)) u_flags (
      .clk(clk), .rst(rst),
      .post_en(post_en), .post_num(post_num), .post_sub(post_sub),
      .clr_en(clr_en), .clr_num(clr_num), .clr_sub(clr_sub),
      .clr_all(clr_all), .flags(flags), .err_pulse(err_pulse)
   );

   vint_gate u_gate (
      .mask     ({mask_a, mask_f, mask_i}),
      .route    ({rt_amo, rt_fmo, rt_imo}),
      .hv_set   ({hv_va, hv_vf, hv_vi}),
      .vflag    ({1'b0, flags[SRC_VFIQ], flags[SRC_VIRQ]}),
      .sec_state(sec_state),
      .hyp_mode (hyp_mode),
      .present  (present),
      .routed   (routed),
      .allowed  (allowed)
   );

   assign phys = {flags[SRC_ABT], flags[SRC_FIQ], flags[SRC_IRQ]};

   assign cand = {
      flags[SRC_SEV],
      flags[SRC_RST],
      present[2] && allowed[2],
      flags[SRC_ABT] && take_abt_ok,
      present[1] && allowed[1],
      flags[SRC_FIQ] && take_fiq_ok,
      present[0] && allowed[0],
      flags[SRC_IRQ] && take_irq_ok
   };

   vint_prio #(.N(NUM_WIN)) u_prio (
      .cand (cand),
      .valid(take_req),
      .code (take_code)
   );

   assign wfi_wake = (|(flags & ~VIRT_BITS)) || (|(present & routed));

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_view
      assign stat_view[c] = routed[c] ? present[c] : phys[c];
   end
endmodule

// File: rtl/vint_select_chk.sv
module vint_select_chk (
   input logic       clk,
   input logic       rst,
   input logic       post_en,
   input logic       clr_en,
   input logic       clr_all,
   input logic       mask_i,
   input logic       rt_imo,
   input logic       rt_fmo,
   input logic       rt_amo,
   input logic       hv_vi,
   input logic       hv_vf,
   input logic       hv_va,
   input logic       sec_state,
   input logic       hyp_mode,
   input logic       take_req,
   input logic [2:0] take_code,
   input logic       wfi_wake,
   input logic [2:0] stat_view,
   input logic       err_pulse
);
   // R3
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (hv_vi || hv_vf || hv_va || !wfi_wake));

   // R2
   clear_all_chk: assert property (@(posedge clk) disable iff (rst)
      $past(clr_all) |-> (rt_imo || rt_fmo || rt_amo || stat_view == 3'b000));

   // R6
   virq_rank_chk: assert property (@(posedge clk) disable iff (rst)
      (hv_vi && !mask_i && rt_imo && !sec_state && !hyp_mode) |-> (take_req && take_code <= 3'd1));

   // R7
   take_wakes_chk: assert property (@(posedge clk) disable iff (rst)
      take_req |-> wfi_wake);

   // R8
   view_virt_chk: assert property (@(posedge clk) disable iff (rst)
      (hv_vi && rt_imo && !sec_state && !hyp_mode) |-> stat_view[0]);

   // R9
   err_source_chk: assert property (@(posedge clk) disable iff (rst)
      err_pulse |-> $past(post_en || clr_en));
endmodule

bind vint_select vint_select_chk u_chk (
   .clk(clk), .rst(rst), .post_en(post_en), .clr_en(clr_en), .clr_all(clr_all),
   .mask_i(mask_i), .rt_imo(rt_imo), .rt_fmo(rt_fmo), .rt_amo(rt_amo),
   .hv_vi(hv_vi), .hv_vf(hv_vf), .hv_va(hv_va),
   .sec_state(sec_state), .hyp_mode(hyp_mode),
   .take_req(take_req), .take_code(take_code), .wfi_wake(wfi_wake),
   .stat_view(stat_view), .err_pulse(err_pulse)
);

// File: tb/tb_vint_select.sv
`timescale 1ns/1ps
module tb_vint_select;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic post_en = 0, clr_en = 0, clr_all = 0;
   logic [3:0] post_num = 0, clr_num = 0;
   logic [1:0] post_sub = 0, clr_sub = 0;
   logic mask_i = 0, mask_f = 0, mask_a = 0;
   logic rt_imo = 0, rt_fmo = 0, rt_amo = 0;
   logic hv_vi = 0, hv_vf = 0, hv_va = 0;
   logic sec_state = 0, hyp_mode = 0;
   logic take_irq_ok = 0, take_fiq_ok = 0, take_abt_ok = 0;
   logic take_req, wfi_wake, err_pulse;
   logic [2:0] take_code, stat_view;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   // behavioural reference state
   bit [6:0] m_pend = '0;
   bit       m_err  = 0;

   always #5 clk = ~clk;

   vint_select dut (
      .clk(clk), .rst(rst),
      .post_en(post_en), .post_num(post_num), .post_sub(post_sub),
      .clr_en(clr_en), .clr_num(clr_num), .clr_sub(clr_sub), .clr_all(clr_all),
      .mask_i(mask_i), .mask_f(mask_f), .mask_a(mask_a),
      .rt_imo(rt_imo), .rt_fmo(rt_fmo), .rt_amo(rt_amo),
      .hv_vi(hv_vi), .hv_vf(hv_vf), .hv_va(hv_va),
      .sec_state(sec_state), .hyp_mode(hyp_mode),
      .take_irq_ok(take_irq_ok), .take_fiq_ok(take_fiq_ok), .take_abt_ok(take_abt_ok),
      .take_req(take_req), .take_code(take_code), .wfi_wake(wfi_wake),
      .stat_view(stat_view), .err_pulse(err_pulse)
   );

   always @(posedge clk) begin
      bit pb, cb;
      pb = post_en && (post_num > 6 || post_sub != 0);
      cb = clr_en  && (clr_num  > 6 || clr_sub  != 0);
      if (rst) begin
         m_pend = '0;
         m_err  = 0;
      end else begin
         m_err = pb || cb;
         if (clr_all) m_pend = '0;
         else begin
            if (post_en && !pb) m_pend[post_num[2:0]] = 1'b1;
            if (clr_en  && !cb) m_pend[clr_num[2:0]]  = 1'b0;
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
         finish_run();
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cmp_all();
      bit ok, vi, vf, va, ri, rf, ra;
      bit [7:0] c;
      int win;
      ok = !sec_state && !hyp_mode;
      vi = m_pend[3] || hv_vi;
      vf = m_pend[4] || hv_vf;
      va = hv_va;
      ri = rt_imo && ok;
      rf = rt_fmo && ok;
      ra = rt_amo && ok;
      c[0] = m_pend[0] && take_irq_ok;
      c[1] = vi && ri && !mask_i;
      c[2] = m_pend[1] && take_fiq_ok;
      c[3] = vf && rf && !mask_f;
      c[4] = m_pend[2] && take_abt_ok;
      c[5] = va && ra && !mask_a;
      c[6] = m_pend[5];
      c[7] = m_pend[6];
      win = -1;
      for (int i = 7; i >= 0; i--) if (c[i]) win = i;
      chk("R5 take_req", take_req, (win >= 0));
      if (win >= 0) chk("R6 take_code", take_code, win);
      chk("R7 wfi_wake", wfi_wake,
          (m_pend[0] || m_pend[1] || m_pend[2] || m_pend[5] || m_pend[6] ||
           (vi && ri) || (vf && rf) || (va && ra)));
      chk("R8 stat_view", stat_view,
          {(ra ? va : m_pend[2]), (rf ? vf : m_pend[1]), (ri ? vi : m_pend[0])});
      chk("R9 err_pulse", err_pulse, m_err);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cmp_all();
   endtask

   task automatic idle();
      post_en = 0; clr_en = 0; clr_all = 0;
      post_num = 0; clr_num = 0; post_sub = 0; clr_sub = 0;
      mask_i = 0; mask_f = 0; mask_a = 0;
      rt_imo = 0; rt_fmo = 0; rt_amo = 0;
      hv_vi = 0; hv_vf = 0; hv_va = 0;
      sec_state = 0; hyp_mode = 0;
      take_irq_ok = 0; take_fiq_ok = 0; take_abt_ok = 0;
   endtask

   task automatic post(int n, int s);
      post_en = 1; post_num = 4'(n); post_sub = 2'(s);
   endtask

   initial begin
      idle();
      rst = 1;
      step(); step(); step();
      // R3: reset leaves everything quiet
      chk("R3 stat_view", stat_view, 0);
      chk("R3 take_req", take_req, 0);
      chk("R3 wfi_wake", wfi_wake, 0);
      chk("R3 err_pulse", err_pulse, 0);
      rst = 0;
      step();

      // R1: post IRQ
      post(0, 0); step(); idle(); #1;
      chk("R1 stat_view I", stat_view, 3'b001);
      take_irq_ok = 1; #1;
      chk("R5 irq take_req", take_req, 1);
      chk("R6 irq code", take_code, 0);

      // R4/R6: add virtual IRQ
      post(3, 0); step(); idle();
      rt_imo = 1; take_irq_ok = 1; #1;
      chk("R6 irq beats virq", take_code, 0);
      take_irq_ok = 0; #1;
      chk("R4 virq allowed", take_req, 1);
      chk("R4 virq code", take_code, 1);
      mask_i = 1; #1;
      chk("R4 virq masked", take_req, 0);
      chk("R7 wake ignores mask", wfi_wake, 1);

      // R2: clear and post of IRQ in one cycle -> clear wins
      idle(); post(0, 0); clr_en = 1; clr_num = 0; step(); idle(); #1;
      chk("R2 clear wins", stat_view, 3'b000);
      chk("R7 virt flag alone", wfi_wake, 0);
      rt_imo = 1; #1;
      chk("R7 routed virq wakes", wfi_wake, 1);
      chk("R8 view virtual I", stat_view, 3'b001);
      sec_state = 1; #1;
      chk("R8 secure shows physical", stat_view, 3'b000);
      chk("R4 secure blocks", take_req, 0);

      // R9: bad number and bad sub-index
      idle(); post(9, 0); step(); idle(); #1;
      chk("R9 err on bad num", err_pulse, 1);
      chk("R9 bad num no change", stat_view, 3'b000);
      step();
      chk("R9 err one cycle", err_pulse, 0);
      post(1, 1); step(); idle(); #1;
      chk("R9 err on bad sub", err_pulse, 1);
      chk("R9 bad sub no change", stat_view[1], 0);

      // R6: reset source and virtual abort
      post(5, 0); step(); idle(); #1;
      chk("R6 rst code", take_code, 6);
      chk("R5 rst take", take_req, 1);
      hv_va = 1; rt_amo = 1; #1;
      chk("R6 vabort beats rst", take_code, 5);

      // R2: clear-all overrides a post in the same cycle
      idle(); clr_all = 1; post(6, 0); step(); idle(); #1;
      chk("R2 clr_all stat", stat_view, 3'b000);
      chk("R2 clr_all take", take_req, 0);
      chk("R2 clr_all wake", wfi_wake, 0);

      // random traffic against the model
      for (int t = 0; t < 4000; t++) begin
         post_en     = ($urandom_range(0, 2) == 0);
         post_num    = 4'($urandom_range(0, 9));
         post_sub    = ($urandom_range(0, 9) == 0) ? 2'd1 : 2'd0;
         clr_en      = ($urandom_range(0, 2) == 0);
         clr_num     = 4'($urandom_range(0, 9));
         clr_sub     = ($urandom_range(0, 9) == 0) ? 2'd2 : 2'd0;
         clr_all     = ($urandom_range(0, 63) == 0);
         rst         = ($urandom_range(0, 499) == 0);
         {mask_i, mask_f, mask_a} = 3'($urandom);
         {rt_imo, rt_fmo, rt_amo} = 3'($urandom);
         hv_vi       = ($urandom_range(0, 5) == 0);
         hv_vf       = ($urandom_range(0, 5) == 0);
         hv_va       = ($urandom_range(0, 5) == 0);
         sec_state   = ($urandom_range(0, 3) == 0);
         hyp_mode    = ($urandom_range(0, 3) == 0);
         {take_irq_ok, take_fiq_ok, take_abt_ok} = 3'($urandom);
         step();
      end
      finish_run();
   end
endmodule